// File: doc/BRIEF.md
# Access Violation Capture Unit

This block records illegal memory accesses reported by the bus requesters around it: a CPU, a DMA engine and two accelerator engines (A and B). The requesters are split into two groups. The controller group covers protected controller memory. The non-controller group covers the remaining memory. Each kind of violation (one requester doing one access type) has a sticky flag and a 32-bit register that holds the address of the faulting access. Each group also has a write-one-to-set register, a write-one-to-clear register and an interrupt enable register.

The decode logic that judges accesses is outside this block. For each violation type it sends a single-cycle event strobe and the address of the access. Software uses a simple register port to read the flags and the captured addresses, to set or clear flags, and to enable interrupts. Writes that modify state are accepted only while the privilege input is high. Each group drives one level interrupt.

Top module: `avc_top`

## Requirements
- R1: An event strobe sets its flag, which reads back one cycle later. The non-controller event index 0..9 maps to flag bit 0 CPU read, 1 CPU write, 2 CPU fetch, 3 DMA write, 4 accel-A read, 5 accel-A write, 6 accel-A fetch, 10 DMA read, 11 accel-B read and 12 accel-B write. The controller event index 0..2 maps to flag bit 0 CPU fetch, 1 CPU write and 2 DMA write. Reserved flag bits read 0. The non-controller flag word is at offset 0x00 and the controller flag word is at 0x20.
- R2: A type's address register loads the event address only if the event arrives while that type's flag is 0. The first faulting address is therefore kept until the flag is cleared. The non-controller address registers for index 0..9 are at 0x08, 0x0A, 0x0C, 0x0E, 0x10, 0x12, 0x14, 0x1C, 0x3A and 0x3C. The controller address registers for index 0..2 are at 0x28, 0x2A and 0x2C.
- R3: Writing a 1 to a bit of a set register (0x02 non-controller, 0x22 controller) forces the matching flag to 1. Zero bits have no effect, and a read of a set register returns 0.
- R4: Writing a 1 to a bit of a clear register (0x04 non-controller, 0x24 controller) forces the matching flag to 0. Zero bits have no effect, and a read of a clear register returns 0.
- R5: When an event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R6: The enable registers (0x06 non-controller, 0x26 controller) are read/write and hold one bit per defined flag. Reserved bits read 0.
- R7: Writes to the set, clear and enable registers have no effect while the privilege input is low.
- R8: Writes to flag registers, to address registers and to unmapped offsets have no effect. Reads of unmapped offsets return 0.
- R9: Each group's interrupt output is high exactly when, in the previous cycle, some flag of that group was set with its enable bit also set.
- R10: A synchronous reset clears every flag, every enable, every address register, the read data and both interrupts.
- R11: A read strobe loads the addressed register into the read data one cycle later. The read data holds its value while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_en | input | 1 | Privilege: enables writes to set, clear and enable registers |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 7 | 16-bit-word register offset |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Registered read data |
| nc_evt | input | 10 | Non-controller violation strobes, by event index |
| nc_evt_addr | input | 10*AW | Faulting address per non-controller event index |
| c_evt | input | 3 | Controller violation strobes, by event index |
| c_evt_addr | input | 3*AW | Faulting address per controller event index |
| irq_nc | output | 1 | Non-controller group interrupt |
| irq_c | output | 1 | Controller group interrupt |

## Verification
The assertions assume that every input holds a defined 0 or 1 at each rising edge. They also assume that an event strobe counts as one violation per cycle it is high, so repeated strobes never count as a fresh first fault. They make no assumption about how reads, writes, privilege and events are mixed. To match this, the stimulus drives every input only on the falling edge and always with defined values. It freely overlaps events with set and clear writes to the same bits, issues writes without privilege, and targets unmapped and read-only offsets.

// File: rtl/avc_pkg.sv
`timescale 1ns/1ps
package avc_pkg;
  localparam int unsigned FLAG_W = 16;
  localparam int unsigned RA_W   = 7;

  typedef logic [RA_W-1:0] roff_t;

  // Defined flag bits of each group (bit position is software-visible)
  localparam logic [FLAG_W-1:0] NC_USED = 16'h1C7F;
  localparam logic [FLAG_W-1:0] C_USED  = 16'h0007;

  localparam roff_t OFF_NC_FLAG = 7'h00;
  localparam roff_t OFF_NC_SET  = 7'h02;
  localparam roff_t OFF_NC_CLR  = 7'h04;
  localparam roff_t OFF_NC_EN   = 7'h06;
  localparam roff_t OFF_C_FLAG  = 7'h20;
  localparam roff_t OFF_C_SET   = 7'h22;
  localparam roff_t OFF_C_CLR   = 7'h24;
  localparam roff_t OFF_C_EN    = 7'h26;
  localparam roff_t OFF_C_ADDR0 = 7'h28;

  function automatic int unsigned ones(logic [FLAG_W-1:0] m);
    int unsigned c;
    c = 0;
    for (int unsigned k = 0; k < FLAG_W; k++) if (m[k]) c++;
    return c;
  endfunction

  // Position of the n-th set bit of m
  function automatic int unsigned nth_set(logic [FLAG_W-1:0] m, int unsigned n);
    int unsigned c;
    int unsigned pos;
    c   = 0;
    pos = 0;
    for (int unsigned k = 0; k < FLAG_W; k++) begin
      if (m[k]) begin
        if (c == n) pos = k;
        c++;
      end
    end
    return pos;
  endfunction

  // Offset of the non-controller address register for event index i
  function automatic roff_t nc_addr_off(int unsigned i);
    if (i < 7)       return roff_t'(8 + 2 * i);
    else if (i == 7) return roff_t'(8'h1C);
    else if (i == 8) return roff_t'(8'h3A);
    else             return roff_t'(8'h3C);
  endfunction
endpackage

// File: rtl/avc_addr_slot.sv
`timescale 1ns/1ps
module avc_addr_slot #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/avc_group.sv
`timescale 1ns/1ps
module avc_group #(
  parameter int unsigned FW   = avc_pkg::FLAG_W,
  parameter logic [FW-1:0] USED = '1,
  parameter int unsigned NT   = 1,
  parameter int unsigned AW   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NT-1:0]    evt,
  input  logic [NT*AW-1:0] evt_addr,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic             en_we,
  input  logic [FW-1:0]    wdata,
  output logic [FW-1:0]    flags,
  output logic [FW-1:0]    enables,
  output logic [NT*AW-1:0] cap_addr,
  output logic             irq
);
  logic [NT-1:0] flag_q, en_q, set_c, clr_c, wen_c;
  logic          irq_q;
  logic          unused_wdata;

  assign unused_wdata = ^(wdata & ~USED);

  for (genvar i = 0; i < NT; i++) begin : g_type
    localparam int unsigned B = avc_pkg::nth_set(USED, i);

    assign set_c[i]   = set_we & wdata[B];
    assign clr_c[i]   = clr_we & wdata[B];
    assign wen_c[i]   = wdata[B];
    assign flags[B]   = flag_q[i];
    assign enables[B] = en_q[i];

    avc_addr_slot #(.AW(AW)) u_slot (
      .clk  (clk),
      .rst  (rst),
      .load (evt[i] & ~flag_q[i]),
      .din  (evt_addr[i*AW +: AW]),
      .q    (cap_addr[i*AW +: AW])
    );

    assert_evt_sets_flag_R1: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> flags[B]);
    assert_first_addr_kept_R2: assert property (@(posedge clk) disable iff (rst)
      flag_q[i] |=> $stable(cap_addr[i*AW +: AW]));
    assert_clear_drops_flag_R4: assert property (@(posedge clk) disable iff (rst)
      (clr_c[i] && !evt[i] && !set_c[i]) |=> !flags[B]);
    assert_evt_beats_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (evt[i] && clr_c[i]) |=> flags[B]);
  end

  for (genvar k = 0; k < FW; k++) begin : g_rsvd
    if (!USED[k]) begin : g_zero
      assign flags[k]   = 1'b0;
      assign enables[k] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= evt | set_c | (flag_q & ~clr_c);
      if (en_we) en_q <= wen_c;
      irq_q  <= |(flag_q & en_q);
    end
  end

  assign irq = irq_q;

  assert_no_enable_no_irq_R9: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq);
endmodule

// File: rtl/avc_top.sv
`timescale 1ns/1ps
module avc_top #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  localparam int unsigned NC_N = avc_pkg::ones(avc_pkg::NC_USED),
  localparam int unsigned C_N  = avc_pkg::ones(avc_pkg::C_USED)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     priv_en,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [avc_pkg::RA_W-1:0] reg_addr,
  input  logic [DW-1:0]            reg_wdata,
  output logic [DW-1:0]            reg_rdata,
  input  logic [NC_N-1:0]          nc_evt,
  input  logic [NC_N*AW-1:0]       nc_evt_addr,
  input  logic [C_N-1:0]           c_evt,
  input  logic [C_N*AW-1:0]        c_evt_addr,
  output logic                     irq_nc,
  output logic                     irq_c
);
  import avc_pkg::*;

  localparam int unsigned FW = FLAG_W;

  logic          wr_ok;
  logic [FW-1:0] wd;
  logic [FW-1:0] nc_flags, nc_en, c_flags, c_en;
  logic [NC_N*AW-1:0] nc_cap;
  logic [C_N*AW-1:0]  c_cap;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] rdata_q;
  logic          unused_wdata_hi;

  assign wr_ok           = reg_wr & priv_en;
  assign wd              = reg_wdata[FW-1:0];
  assign unused_wdata_hi = ^reg_wdata;

  avc_group #(.FW(FW), .USED(NC_USED), .NT(NC_N), .AW(AW)) u_nc (
    .clk      (clk),
    .rst      (rst),
    .evt      (nc_evt),
    .evt_addr (nc_evt_addr),
    .set_we   (wr_ok && reg_addr == OFF_NC_SET),
    .clr_we   (wr_ok && reg_addr == OFF_NC_CLR),
    .en_we    (wr_ok && reg_addr == OFF_NC_EN),
    .wdata    (wd),
    .flags    (nc_flags),
    .enables  (nc_en),
    .cap_addr (nc_cap),
    .irq      (irq_nc)
  );

  avc_group #(.FW(FW), .USED(C_USED), .NT(C_N), .AW(AW)) u_c (
    .clk      (clk),
    .rst      (rst),
    .evt      (c_evt),
    .evt_addr (c_evt_addr),
    .set_we   (wr_ok && reg_addr == OFF_C_SET),
    .clr_we   (wr_ok && reg_addr == OFF_C_CLR),
    .en_we    (wr_ok && reg_addr == OFF_C_EN),
    .wdata    (wd),
    .flags    (c_flags),
    .enables  (c_en),
    .cap_addr (c_cap),
    .irq      (irq_c)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFF_NC_FLAG: rd_mux = DW'(nc_flags);
      OFF_NC_EN:   rd_mux = DW'(nc_en);
      OFF_C_FLAG:  rd_mux = DW'(c_flags);
      OFF_C_EN:    rd_mux = DW'(c_en);
      default:     rd_mux = '0;
    endcase
    for (int unsigned i = 0; i < NC_N; i++)
      if (reg_addr == nc_addr_off(i)) rd_mux = DW'(nc_cap[i*AW +: AW]);
    for (int unsigned i = 0; i < C_N; i++)
      if (reg_addr == roff_t'(OFF_C_ADDR0 + 2 * i)) rd_mux = DW'(c_cap[i*AW +: AW]);
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;

  assert_nopriv_enable_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !priv_en) |=> ($stable(nc_en) && $stable(c_en)));
  assert_set_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (reg_addr == OFF_NC_SET || reg_addr == OFF_C_SET)) |=> (reg_rdata == '0));
  assert_clr_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (reg_addr == OFF_NC_CLR || reg_addr == OFF_C_CLR)) |=> (reg_rdata == '0));
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/sim_avc_top.sv
`timescale 1ns/1ps
module sim_avc_top;
  localparam int AW = 32;
  localparam int NC_N = 10;
  localparam int C_N = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic priv_en = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NC_N-1:0]    nc_evt = '0;
  logic [NC_N*AW-1:0] nc_evt_addr = '0;
  logic [C_N-1:0]     c_evt = '0;
  logic [C_N*AW-1:0]  c_evt_addr = '0;
  logic irq_nc, irq_c;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  avc_top u0 (
    .clk(clk), .rst(rst), .priv_en(priv_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nc_evt(nc_evt), .nc_evt_addr(nc_evt_addr), .c_evt(c_evt), .c_evt_addr(c_evt_addr),
    .irq_nc(irq_nc), .irq_c(irq_c)
  );

  // Reference model
  int nc_bit [NC_N] = '{0, 1, 2, 3, 4, 5, 6, 10, 11, 12};
  int nc_off [NC_N] = '{8, 10, 12, 14, 16, 18, 20, 28, 58, 60};
  logic [15:0] ncm, m_ncf, m_nce, m_cf, m_ce, nf, cf;
  logic [31:0] m_nca [NC_N];
  logic [31:0] m_ca [C_N];
  logic m_irq_nc, m_irq_c;
  logic [31:0] m_rdata;
  bit ok;

  function automatic logic [31:0] m_read(int a);
    logic [31:0] r;
    r = 0;
    if (a == 0) r = {16'h0, m_ncf};
    if (a == 6) r = {16'h0, m_nce};
    if (a == 32) r = {16'h0, m_cf};
    if (a == 38) r = {16'h0, m_ce};
    for (int i = 0; i < NC_N; i++) if (a == nc_off[i]) r = m_nca[i];
    for (int i = 0; i < C_N; i++) if (a == 40 + 2 * i) r = m_ca[i];
    return r;
  endfunction

  always @(posedge clk) begin
    ncm = 0;
    for (int i = 0; i < NC_N; i++) ncm[nc_bit[i]] = 1'b1;
    if (rst) begin
      m_ncf = 0; m_nce = 0; m_cf = 0; m_ce = 0;
      for (int i = 0; i < NC_N; i++) m_nca[i] = 0;
      for (int i = 0; i < C_N; i++) m_ca[i] = 0;
      m_irq_nc = 0; m_irq_c = 0; m_rdata = 0;
    end else begin
      if (reg_rd) m_rdata = m_read(int'(reg_addr));
      m_irq_nc = |(m_ncf & m_nce);
      m_irq_c  = |(m_cf & m_ce);
      ok = reg_wr && priv_en;
      for (int i = 0; i < NC_N; i++)
        if (nc_evt[i] && !m_ncf[nc_bit[i]]) m_nca[i] = nc_evt_addr[i*32 +: 32];
      for (int i = 0; i < C_N; i++)
        if (c_evt[i] && !m_cf[i]) m_ca[i] = c_evt_addr[i*32 +: 32];
      nf = m_ncf;
      cf = m_cf;
      if (ok && reg_addr == 7'h04) nf = nf & ~reg_wdata[15:0];
      if (ok && reg_addr == 7'h02) nf = nf | reg_wdata[15:0];
      if (ok && reg_addr == 7'h24) cf = cf & ~reg_wdata[15:0];
      if (ok && reg_addr == 7'h22) cf = cf | reg_wdata[15:0];
      for (int i = 0; i < NC_N; i++) if (nc_evt[i]) nf[nc_bit[i]] = 1'b1;
      for (int i = 0; i < C_N; i++) if (c_evt[i]) cf[i] = 1'b1;
      m_ncf = nf & ncm;
      m_cf  = cf & 16'h0007;
      if (ok && reg_addr == 7'h06) m_nce = reg_wdata[15:0] & ncm;
      if (ok && reg_addr == 7'h26) m_ce = reg_wdata[15:0] & 16'h0007;
    end
  end

  task automatic chk(input bit good, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(reg_rdata === m_rdata, "R11 read data vs model", reg_rdata, m_rdata);
      chk(irq_nc === m_irq_nc, "R9 irq_nc vs model", 32'(irq_nc), 32'(m_irq_nc));
      chk(irq_c === m_irq_c, "R9 irq_c vs model", 32'(irq_c), 32'(m_irq_c));
    end
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic pv);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; priv_en = pv;
    @(negedge clk);
    reg_wr = 1'b0; priv_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [6:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic nc_pulse(input int idx, input logic [31:0] a);
    @(negedge clk);
    nc_evt[idx] = 1'b1; nc_evt_addr[idx*32 +: 32] = a;
    @(negedge clk);
    nc_evt = '0;
  endtask

  logic [6:0] addr_list [24] = '{7'h00, 7'h02, 7'h04, 7'h06, 7'h08, 7'h0A, 7'h0C, 7'h0E,
                                 7'h10, 7'h12, 7'h14, 7'h1C, 7'h3A, 7'h3C, 7'h20, 7'h22,
                                 7'h24, 7'h26, 7'h28, 7'h2A, 7'h2C, 7'h3E, 7'h16, 7'h30};

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    rd_expect(7'h00, 32'h0, "R10 nc flags after reset");
    rd_expect(7'h20, 32'h0, "R10 c flags after reset");
    rd_expect(7'h1C, 32'h0, "R10 address after reset");
    rd_expect(7'h06, 32'h0, "R10 nc enable after reset");
    chk(irq_nc === 1'b0, "R10 irq_nc after reset", 32'(irq_nc), 0);
    // R1 / R2 capture
    nc_pulse(7, 32'hA000_1234);
    rd_expect(7'h00, 32'h0000_0400, "R1 DMA read flag at bit 10");
    rd_expect(7'h1C, 32'hA000_1234, "R2 DMA read address");
    nc_pulse(7, 32'hBBBB_0000);
    rd_expect(7'h1C, 32'hA000_1234, "R2 first address kept");
    nc_pulse(9, 32'h0000_3C3C);
    rd_expect(7'h3C, 32'h0000_3C3C, "R2 accel-B write address");
    rd_expect(7'h00, 32'h0000_1400, "R1 accel-B write flag at bit 12");
    // R7 privilege
    wr(7'h06, 32'hFFFF_FFFF, 1'b0);
    rd_expect(7'h06, 32'h0, "R7 enable write without privilege");
    chk(irq_nc === 1'b0, "R7 irq stays low", 32'(irq_nc), 0);
    // R6 / R9
    wr(7'h06, 32'hFFFF_FFFF, 1'b1);
    rd_expect(7'h06, 32'h0000_1C7F, "R6 enable holds only defined bits");
    chk(irq_nc === 1'b1, "R9 irq_nc raised", 32'(irq_nc), 1);
    wr(7'h04, 32'h0000_0400, 1'b0);
    rd_expect(7'h00, 32'h0000_1400, "R7 clear without privilege");
    // R4 clear
    wr(7'h04, 32'h0000_0400, 1'b1);
    rd_expect(7'h00, 32'h0000_1000, "R4 clear one flag");
    wr(7'h04, 32'h0, 1'b1);
    rd_expect(7'h00, 32'h0000_1000, "R4 zero bits no effect");
    wr(7'h04, 32'h0000_1000, 1'b1);
    rd_expect(7'h00, 32'h0, "R4 all clear");
    chk(irq_nc === 1'b0, "R9 irq_nc dropped", 32'(irq_nc), 0);
    nc_pulse(7, 32'h0000_5555);
    rd_expect(7'h1C, 32'h0000_5555, "R2 reload after clear");
    // R3 set
    wr(7'h22, 32'h0000_000F, 1'b1);
    rd_expect(7'h20, 32'h0000_0007, "R3 set controller flags");
    rd_expect(7'h22, 32'h0, "R3 set register reads 0");
    rd_expect(7'h24, 32'h0, "R4 clear register reads 0");
    // R8 read-only and unmapped
    wr(7'h20, 32'h0, 1'b1);
    rd_expect(7'h20, 32'h0000_0007, "R8 flag register not writable");
    wr(7'h28, 32'h0000_DEAD, 1'b1);
    rd_expect(7'h28, 32'h0, "R8 address register not writable");
    rd_expect(7'h3E, 32'h0, "R8 unmapped reads 0");
    // R5 event beats clear
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 7'h24; reg_wdata = 32'h2; priv_en = 1'b1;
    c_evt[1] = 1'b1; c_evt_addr[32 +: 32] = 32'h77;
    @(negedge clk);
    reg_wr = 1'b0; priv_en = 1'b0; c_evt = '0;
    rd_expect(7'h20, 32'h0000_0007, "R5 event wins over clear");
    rd_expect(7'h2A, 32'h0, "R2 no capture while flag set");
    wr(7'h24, 32'h7, 1'b1);
    rd_expect(7'h20, 32'h0, "R4 controller clear");
    // R11 hold
    held = reg_rdata;
    @(negedge clk); reg_addr = 7'h06;
    @(negedge clk);
    chk(reg_rdata === held, "R11 data held without read", reg_rdata, held);
    // Controller interrupt
    @(negedge clk); c_evt[2] = 1'b1; c_evt_addr[64 +: 32] = 32'h99;
    @(negedge clk); c_evt = '0;
    @(negedge clk);
    chk(irq_c === 1'b0, "R9 irq_c disabled", 32'(irq_c), 0);
    wr(7'h26, 32'h4, 1'b1);
    @(negedge clk);
    chk(irq_c === 1'b1, "R9 irq_c enabled", 32'(irq_c), 1);
    rd_expect(7'h26, 32'h4, "R6 controller enable");
    rd_expect(7'h2C, 32'h99, "R2 controller DMA write address");
    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      int op;
      int pick;
      @(negedge clk);
      for (int i = 0; i < NC_N; i++) begin
        nc_evt[i] = ($urandom % 10) == 0;
        nc_evt_addr[i*32 +: 32] = $urandom;
      end
      for (int i = 0; i < C_N; i++) begin
        c_evt[i] = ($urandom % 10) == 0;
        c_evt_addr[i*32 +: 32] = $urandom;
      end
      op = int'($urandom % 4);
      reg_wr = op[0];
      reg_rd = op[1];
      pick = int'($urandom % 28);
      reg_addr = (pick < 24) ? addr_list[pick] : 7'($urandom);
      reg_wdata = $urandom;
      priv_en = ($urandom % 4) != 0;
    end
    @(negedge clk);
    nc_evt = '0; c_evt = '0; reg_wr = 1'b0; reg_rd = 1'b0; priv_en = 1'b0;
    // R10 reset again
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd_expect(7'h00, 32'h0, "R10 nc flags cleared by reset");
    rd_expect(7'h06, 32'h0, "R10 nc enable cleared by reset");
    rd_expect(7'h3C, 32'h0, "R10 address cleared by reset");
    rd_expect(7'h26, 32'h0, "R10 c enable cleared by reset");
    chk(irq_nc === 1'b0 && irq_c === 1'b0, "R10 irqs low after reset", {30'h0, irq_nc, irq_c}, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule